// File: doc/BRIEF.md
# Four-Thread Round-Robin Instruction Fetch Slicer

This block is the fetch-stage controller of a core that runs four hardware threads. Each cycle it chooses one eligible thread in rotation, asks the instruction cache for the aligned fetch block that holds that thread's program counter, and sends a request for the next sequential line as a prefetch. The block has eight 4-byte instruction slots. With the cache's answer comes a per-slot predicted-taken vector and a target address for each slot. From these the block builds a mask of the slots that are really delivered. Slots below the starting offset are dropped. The block stops after the first slot predicted taken, and that slot is kept. The block also works out where the thread fetches next.

The thread's program counter is then replaced by that next address. Outside requests can redirect any thread. A redirect that hits the thread being fetched in the same cycle cancels that fetch. A cache that is not ready holds the rotation, so the same thread retries.

Each cycle falls into one of four named states. `ST_IDLE` means no thread is eligible. `ST_SQUASH` means the selected thread was redirected. `ST_STALL` means the cache was not ready. `ST_FETCH` means a block was delivered. The next state is worked out from the inputs every cycle, with priority in that order. Every state can follow every other. The delivered outputs are valid in the cycle after a transition into `ST_FETCH`.

Top module: `fetch_slicer`

## Requirements
- R1: After reset, `fo_valid` is 0, every thread's PC equals the parameter BOOT_PC (default 0), and the rotation starts at thread 0.
- R2: Each delivered fetch moves the rotation to the thread after the one just served. With all four threads eligible and the cache ready, the delivered thread IDs run 0,1,2,3,0,...
- R3: A thread is eligible when `thr_active[t]` is 1 and `thr_stall[t]` is 0. Ineligible threads are skipped. When no thread is eligible, `ic_req_valid` and `pf_valid` are 0 and nothing is delivered.
- R4: When `ic_ready` is 0 with a request out, nothing is delivered. The rotation holds, so the same thread is requested next cycle if it is still eligible.
- R5: `ic_req_addr` is the selected thread's PC with its low 5 bits cleared. `pf_valid` equals `ic_req_valid`, and `pf_addr` is `ic_req_addr + 32`.
- R6: Slot i covers bytes 4i..4i+3 of the block. Bit i of `fo_mask` is 0 for every i below the start offset PC[4:2].
- R7: Among the slots at or above the start offset, delivery ends at the first one whose `ic_taken` bit is 1. That slot is delivered, and later slots are cleared. Taken bits below the start offset are ignored. If none is taken, all slots from the offset up to 7 are delivered.
- R8: `fo_next_pc` is `ic_targets[32k +: 32]` for the first taken delivered slot k. If no slot is taken, it is the block address plus 32.
- R9: A redirect (`redir_valid`, `redir_tid`, `redir_pc`) overwrites that thread's PC. The next request for that thread uses the redirected address.
- R10: A redirect naming the thread being requested in the same cycle cancels that fetch. Nothing is delivered, and that thread is requested again next cycle from the new PC.
- R11: A fetch with `ic_ready` 1 is delivered on the next clock edge: `fo_valid` is 1, `fo_tid` is the requested thread, and that thread's PC becomes `fo_next_pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_active | input | 4 | Per-thread enable |
| thr_stall | input | 4 | Per-thread stall, excludes the thread from rotation |
| redir_valid | input | 1 | Redirect strobe |
| redir_tid | input | 2 | Thread to redirect |
| redir_pc | input | 32 | New PC for the redirected thread |
| ic_ready | input | 1 | Cache read data and prediction valid this cycle |
| ic_taken | input | 8 | Predicted-taken flag per slot |
| ic_targets | input | 256 | Predicted target per slot, slot i at bits 32i+31:32i |
| ic_req_valid | output | 1 | Fetch request valid |
| ic_req_tid | output | 2 | Thread of the request |
| ic_req_addr | output | 32 | Aligned block address requested |
| pf_valid | output | 1 | Next-line prefetch request valid |
| pf_addr | output | 32 | Next sequential block address |
| fo_valid | output | 1 | Delivered fetch valid (registered) |
| fo_tid | output | 2 | Thread of the delivered fetch |
| fo_mask | output | 8 | Valid slot mask of the delivered fetch |
| fo_next_pc | output | 32 | Next fetch PC of the delivered thread |

## Verification
The slot logic is swept over every start offset paired with every one of the 256 taken patterns. This separates the offset cut from the taken cut, and it shows whether taken bits below the offset leak into the result. A free-running rotation with all threads eligible checks the order and the sequential PC advance. A sparse eligibility pattern, followed by an empty one, separates skipping from idling. Single cycles with the cache not ready, and redirects that either hit or miss the selected thread, tell a retry apart from a move to the next thread, and a cancelled fetch apart from a plain PC overwrite.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_STALL  = 2'd2,
        ST_SQUASH = 2'd3
    } fetch_st_e;
endpackage

// File: rtl/rr_picker.sv
module rr_picker #(
    parameter int N     = 4,
    localparam int TW   = $clog2(N)
) (
    input  logic [N-1:0]  elig,
    input  logic [TW-1:0] ptr,
    output logic          any,
    output logic [TW-1:0] sel
);
    always_comb begin
        any = 1'b0;
        sel = ptr;
        for (int k = 0; k < N; k++) begin
            logic [TW-1:0] idx;
            idx = ptr + TW'(k);
            if (!any && elig[idx]) begin
                any = 1'b1;
                sel = idx;
            end
        end
    end
endmodule

// File: rtl/slot_cutter.sv
module slot_cutter #(
    parameter int SLOTS  = 8,
    parameter int ADDR_W = 32,
    localparam int OFF_W = $clog2(SLOTS)
) (
    input  logic [OFF_W-1:0]        off,
    input  logic [ADDR_W-1:0]       seq_pc,
    input  logic [SLOTS-1:0]        taken,
    input  logic [SLOTS*ADDR_W-1:0] targets,
    output logic [SLOTS-1:0]        mask,
    output logic [ADDR_W-1:0]       next_pc
);
    logic [SLOTS:0]    blocked;
    logic [SLOTS-1:0]  hit;
    assign blocked[0] = 1'b0;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        logic in_range;
        assign in_range     = (OFF_W'(i) >= off);
        assign mask[i]      = in_range && !blocked[i];
        assign hit[i]       = mask[i] && taken[i];
        assign blocked[i+1] = blocked[i] || hit[i];
    end

    always_comb begin
        next_pc = seq_pc;
        for (int i = 0; i < SLOTS; i++) begin
            if (hit[i]) next_pc = targets[i*ADDR_W +: ADDR_W];
        end
    end
endmodule

// File: rtl/pc_bank.sv
module pc_bank #(
    parameter int          N       = 4,
    parameter int          ADDR_W  = 32,
    parameter logic [31:0] BOOT_PC = 32'h0,
    localparam int         TW      = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [TW-1:0]     upd_tid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              redir_en,
    input  logic [TW-1:0]     redir_tid,
    input  logic [ADDR_W-1:0] redir_pc,
    input  logic [TW-1:0]     rd_tid,
    output logic [ADDR_W-1:0] rd_pc
);
    logic [ADDR_W-1:0] pc_q [N];

    for (genvar t = 0; t < N; t++) begin : g_thr
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pc_q[t] <= ADDR_W'(BOOT_PC);
            end else if (redir_en && redir_tid == TW'(t)) begin
                pc_q[t] <= redir_pc;
            end else if (upd_en && upd_tid == TW'(t)) begin
                pc_q[t] <= upd_pc;
            end
        end
    end

    assign rd_pc = pc_q[rd_tid];
endmodule

// File: rtl/fetch_slicer.sv
module fetch_slicer
    import fetch_pkg::*;
#(
    parameter int          N_THR   = 4,
    parameter int          SLOTS   = 8,
    parameter int          ADDR_W  = 32,
    parameter logic [31:0] BOOT_PC = 32'h0,
    localparam int         TW      = $clog2(N_THR),
    localparam int         OFF_W   = $clog2(SLOTS),
    localparam int         BLK_W   = OFF_W + 2,
    localparam int         BLK_B   = SLOTS * 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_THR-1:0]        thr_active,
    input  logic [N_THR-1:0]        thr_stall,
    input  logic                    redir_valid,
    input  logic [TW-1:0]           redir_tid,
    input  logic [ADDR_W-1:0]       redir_pc,
    input  logic                    ic_ready,
    input  logic [SLOTS-1:0]        ic_taken,
    input  logic [SLOTS*ADDR_W-1:0] ic_targets,
    output logic                    ic_req_valid,
    output logic [TW-1:0]           ic_req_tid,
    output logic [ADDR_W-1:0]       ic_req_addr,
    output logic                    pf_valid,
    output logic [ADDR_W-1:0]       pf_addr,
    output logic                    fo_valid,
    output logic [TW-1:0]           fo_tid,
    output logic [SLOTS-1:0]        fo_mask,
    output logic [ADDR_W-1:0]       fo_next_pc
);
    fetch_st_e          st_q, st_nxt;
    logic [TW-1:0]      rr_ptr, ptr_nxt;
    logic [N_THR-1:0]   elig;
    logic               any_elig, squash, do_fetch;
    logic [TW-1:0]      sel;
    logic [ADDR_W-1:0]  cur_pc, blk_addr, seq_pc, cut_next;
    logic [SLOTS-1:0]   cut_mask;

    assign elig = thr_active & ~thr_stall;

    rr_picker #(.N(N_THR)) i_pick (
        .elig (elig),
        .ptr  (rr_ptr),
        .any  (any_elig),
        .sel  (sel)
    );

    pc_bank #(.N(N_THR), .ADDR_W(ADDR_W), .BOOT_PC(BOOT_PC)) i_pcs (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en    (do_fetch),
        .upd_tid   (sel),
        .upd_pc    (cut_next),
        .redir_en  (redir_valid),
        .redir_tid (redir_tid),
        .redir_pc  (redir_pc),
        .rd_tid    (sel),
        .rd_pc     (cur_pc)
    );

    assign blk_addr = {cur_pc[ADDR_W-1:BLK_W], {BLK_W{1'b0}}};
    assign seq_pc   = blk_addr + ADDR_W'(BLK_B);

    slot_cutter #(.SLOTS(SLOTS), .ADDR_W(ADDR_W)) i_cut (
        .off     (cur_pc[BLK_W-1:2]),
        .seq_pc  (seq_pc),
        .taken   (ic_taken),
        .targets (ic_targets),
        .mask    (cut_mask),
        .next_pc (cut_next)
    );

    assign ic_req_valid = any_elig;
    assign ic_req_tid   = sel;
    assign ic_req_addr  = blk_addr;
    assign pf_valid     = any_elig;
    assign pf_addr      = seq_pc;

    assign squash = redir_valid && (redir_tid == sel);

    // next-state selection, priority idle > squash > stall > fetch
    always_comb begin
        if (!any_elig)      st_nxt = ST_IDLE;
        else if (squash)    st_nxt = ST_SQUASH;
        else if (!ic_ready) st_nxt = ST_STALL;
        else                st_nxt = ST_FETCH;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            rr_ptr <= '0;
        end else begin
            st_q   <= st_nxt;
            rr_ptr <= ptr_nxt;
        end
    end

    // per-state actions
    always_comb begin
        do_fetch = 1'b0;
        ptr_nxt  = rr_ptr;
        unique case (st_nxt)
            ST_IDLE:   ptr_nxt = rr_ptr;
            ST_SQUASH: ptr_nxt = sel;
            ST_STALL:  ptr_nxt = sel;
            ST_FETCH: begin
                do_fetch = 1'b1;
                ptr_nxt  = sel + TW'(1);
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fo_tid     <= '0;
            fo_mask    <= '0;
            fo_next_pc <= '0;
        end else if (do_fetch) begin
            fo_tid     <= sel;
            fo_mask    <= cut_mask;
            fo_next_pc <= cut_next;
        end
    end

    assign fo_valid = (st_q == ST_FETCH);
endmodule

// File: rtl/fetch_slicer_chk.sv
module fetch_slicer_chk #(
    parameter int N_THR  = 4,
    parameter int SLOTS  = 8,
    parameter int ADDR_W = 32,
    localparam int TW    = $clog2(N_THR),
    localparam int BLK_W = $clog2(SLOTS) + 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_THR-1:0]  thr_active,
    input logic [N_THR-1:0]  thr_stall,
    input logic              redir_valid,
    input logic [TW-1:0]     redir_tid,
    input logic              ic_ready,
    input logic              ic_req_valid,
    input logic [TW-1:0]     ic_req_tid,
    input logic [ADDR_W-1:0] ic_req_addr,
    input logic              pf_valid,
    input logic              fo_valid,
    input logic [TW-1:0]     fo_tid,
    input logic [SLOTS-1:0]  fo_mask
);
    logic [N_THR-1:0] elig;
    logic [SLOTS-1:0] low_bit;
    logic             contig;
    assign elig    = thr_active & ~thr_stall;
    assign low_bit = fo_mask & (~fo_mask + SLOTS'(1));
    assign contig  = ((fo_mask + low_bit) & fo_mask) == '0;

    assert_req_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ic_req_valid |-> (ic_req_addr[BLK_W-1:0] == '0 && pf_valid));

    assert_no_eligible_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (elig == '0) |-> !ic_req_valid);

    assert_mask_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fo_valid |-> (fo_mask != '0 && contig));

    assert_retry_same_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ic_req_valid && !ic_ready) |=>
            (!fo_valid && (!elig[$past(ic_req_tid)] || ic_req_tid == $past(ic_req_tid))));

    assert_squash_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ic_req_valid && redir_valid && redir_tid == ic_req_tid) |=> !fo_valid);

    assert_deliver_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ic_req_valid && ic_ready && !(redir_valid && redir_tid == ic_req_tid))
            |=> (fo_valid && fo_tid == $past(ic_req_tid)));
endmodule

bind fetch_slicer fetch_slicer_chk #(.N_THR(N_THR), .SLOTS(SLOTS), .ADDR_W(ADDR_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .thr_active   (thr_active),
    .thr_stall    (thr_stall),
    .redir_valid  (redir_valid),
    .redir_tid    (redir_tid),
    .ic_ready     (ic_ready),
    .ic_req_valid (ic_req_valid),
    .ic_req_tid   (ic_req_tid),
    .ic_req_addr  (ic_req_addr),
    .pf_valid     (pf_valid),
    .fo_valid     (fo_valid),
    .fo_tid       (fo_tid),
    .fo_mask      (fo_mask)
);

// File: tb/test_fetch_slicer.sv
`timescale 1ns/1ps
module test_fetch_slicer;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   thr_active = '0;
    logic [3:0]   thr_stall = '0;
    logic         redir_valid = 1'b0;
    logic [1:0]   redir_tid = '0;
    logic [31:0]  redir_pc = '0;
    logic         ic_ready = 1'b0;
    logic [7:0]   ic_taken = '0;
    logic [255:0] ic_targets = '0;
    logic         ic_req_valid, pf_valid, fo_valid;
    logic [1:0]   ic_req_tid, fo_tid;
    logic [31:0]  ic_req_addr, pf_addr, fo_next_pc;
    logic [7:0]   fo_mask;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    fetch_slicer i_fetch_slicer (
        .clk(clk), .rst_n(rst_n), .thr_active(thr_active), .thr_stall(thr_stall),
        .redir_valid(redir_valid), .redir_tid(redir_tid), .redir_pc(redir_pc),
        .ic_ready(ic_ready), .ic_taken(ic_taken), .ic_targets(ic_targets),
        .ic_req_valid(ic_req_valid), .ic_req_tid(ic_req_tid), .ic_req_addr(ic_req_addr),
        .pf_valid(pf_valid), .pf_addr(pf_addr), .fo_valid(fo_valid), .fo_tid(fo_tid),
        .fo_mask(fo_mask), .fo_next_pc(fo_next_pc)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; redir_valid = 1'b0; ic_ready = 1'b0; ic_taken = '0;
        thr_active = '0; thr_stall = '0;
        @(posedge clk); @(posedge clk); #1;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // drive at the falling edge, settle, then wait for the rising edge
    task automatic drive(input logic [3:0] act, input logic rdy, input logic rv,
                         input logic [1:0] rt, input logic [31:0] rp);
        @(negedge clk);
        thr_active = act; ic_ready = rdy;
        redir_valid = rv; redir_tid = rt; redir_pc = rp;
        #1;
    endtask

    task automatic edge_wait();
        @(posedge clk); #1;
    endtask

    function automatic logic [7:0] exp_mask(input int off, input logic [7:0] m);
        logic [7:0] r = '0;
        bit blk = 0;
        for (int i = 0; i < 8; i++) begin
            if (i >= off && !blk) begin
                r[i] = 1'b1;
                if (m[i]) blk = 1;
            end
        end
        return r;
    endfunction

    function automatic logic [31:0] exp_next(input int off, input logic [7:0] m,
                                             input logic [31:0] blk_a, input logic [255:0] tg);
        for (int i = 0; i < 8; i++) begin
            if (i >= off && m[i]) return tg[i*32 +: 32];
        end
        return blk_a + 32'd32;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        summary();
    end

    initial begin
        logic [1:0] held;
        do_reset();
        // R1: reset state
        #1;
        chk(fo_valid == 1'b0, "R1 fo_valid", fo_valid, 0);
        thr_active = 4'hF; #1;
        chk(ic_req_tid == 2'd0 && ic_req_addr == 32'h0, "R1 start thread/pc", {ic_req_tid, ic_req_addr}, 0);

        // R2/R11: free rotation, sequential PCs
        for (int k = 0; k < 8; k++) begin
            drive(4'hF, 1'b1, 1'b0, 2'd0, 32'h0);
            chk(ic_req_tid == 2'(k % 4), "R2 request order", ic_req_tid, k % 4);
            chk(ic_req_addr == 32'((k / 4) * 32), "R11 pc advanced", ic_req_addr, (k / 4) * 32);
            chk(pf_valid && pf_addr == ic_req_addr + 32, "R5 prefetch line", pf_addr, ic_req_addr + 32);
            edge_wait();
            chk(fo_valid && fo_tid == 2'(k % 4), "R11 delivered thread", {fo_valid, fo_tid}, {1'b1, 2'(k % 4)});
            chk(fo_next_pc == 32'((k / 4 + 1) * 32) && fo_mask == 8'hFF, "R8 sequential next",
                fo_next_pc, (k / 4 + 1) * 32);
        end

        // R3: skipping and idling
        do_reset();
        thr_stall = 4'b0010;
        for (int k = 0; k < 2; k++) begin
            drive(4'b1010, 1'b1, 1'b0, 2'd0, 32'h0);
            chk(ic_req_valid && ic_req_tid == 2'd3, "R3 skip ineligible", ic_req_tid, 3);
            edge_wait();
            chk(fo_valid && fo_tid == 2'd3, "R3 served thread", fo_tid, 3);
        end
        thr_stall = 4'b0000;
        drive(4'hF, 1'b1, 1'b0, 2'd0, 32'h0);
        chk(ic_req_tid == 2'd0, "R2 wrap after thread 3", ic_req_tid, 0);
        edge_wait();
        drive(4'h0, 1'b1, 1'b0, 2'd0, 32'h0);
        chk(!ic_req_valid && !pf_valid, "R3 no request when none eligible", {ic_req_valid, pf_valid}, 0);
        edge_wait();
        chk(!fo_valid, "R3 no delivery when idle", fo_valid, 0);

        // R4: cache not ready holds the thread
        do_reset();
        drive(4'hF, 1'b1, 1'b0, 2'd0, 32'h0);
        edge_wait();
        drive(4'hF, 1'b0, 1'b0, 2'd0, 32'h0);
        held = ic_req_tid;
        chk(held == 2'd1, "R4 pre-stall thread", held, 1);
        edge_wait();
        chk(!fo_valid, "R4 nothing delivered on stall", fo_valid, 0);
        drive(4'hF, 1'b1, 1'b0, 2'd0, 32'h0);
        chk(ic_req_tid == held, "R4 same thread retried", ic_req_tid, held);
        edge_wait();
        chk(fo_valid && fo_tid == held, "R4 retry delivered", fo_tid, held);

        // R9: redirect to another thread
        do_reset();
        drive(4'hF, 1'b1, 1'b1, 2'd2, 32'h0000_0500);
        chk(ic_req_tid == 2'd0, "R9 other thread fetched", ic_req_tid, 0);
        edge_wait();
        chk(fo_valid && fo_tid == 2'd0, "R9 fetch unaffected", fo_tid, 0);
        drive(4'hF, 1'b1, 1'b0, 2'd0, 32'h0);
        edge_wait();
        drive(4'hF, 1'b1, 1'b0, 2'd0, 32'h0);
        chk(ic_req_tid == 2'd2 && ic_req_addr == 32'h500, "R9 redirected address", ic_req_addr, 32'h500);
        edge_wait();
        chk(fo_next_pc == 32'h520, "R9 next after redirect", fo_next_pc, 32'h520);

        // R10: redirect hits the thread being fetched
        do_reset();
        drive(4'hF, 1'b1, 1'b1, 2'd0, 32'h0000_1234);
        edge_wait();
        chk(!fo_valid, "R10 fetch cancelled", fo_valid, 0);
        drive(4'hF, 1'b1, 1'b0, 2'd0, 32'h0);
        chk(ic_req_tid == 2'd0 && ic_req_addr == 32'h1220, "R10 refetch new pc", ic_req_addr, 32'h1220);
        edge_wait();
        chk(fo_valid && fo_mask == 8'hE0 && fo_next_pc == 32'h1240, "R6 offset cut after redirect",
            {fo_mask, fo_next_pc}, {8'hE0, 32'h1240});

        // R6/R7/R8: sweep offsets against all taken patterns
        do_reset();
        for (int off = 0; off < 8; off++) begin
            for (int m = 0; m < 256; m++) begin
                logic [31:0] base;
                base = 32'h0008_0000 + 32'(m * 64);
                drive(4'b0001, 1'b0, 1'b1, 2'd0, base + 32'(off * 4));
                edge_wait();
                drive(4'b0001, 1'b1, 1'b0, 2'd0, 32'h0);
                ic_taken = 8'(m);
                for (int i = 0; i < 8; i++) ic_targets[i*32 +: 32] = 32'h4000_0000 + 32'(i * 256 + off * 4);
                #1;
                edge_wait();
                chk(fo_valid && fo_mask == exp_mask(off, 8'(m)), "R7 slot mask",
                    fo_mask, exp_mask(off, 8'(m)));
                chk(fo_next_pc == exp_next(off, 8'(m), base, ic_targets), "R8 next pc",
                    fo_next_pc, exp_next(off, 8'(m), base, ic_targets));
            end
        end
        summary();
    end
endmodule